// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of a read or write burst on a synchronous DRAM page. When a read or write command is accepted, the controller presents the starting column together with the programmed burst length and ordering. From the following cycle the generator walks through the burst, one beat per enabled clock, and raises a flag on the last beat.

Short bursts of 1, 2, 4 or 8 beats stay inside the aligned block of columns that the length defines. Only the low-order column bits move, and they move either sequentially (add and wrap) or interleaved (exclusive-or with the beat count). A full-page burst walks all 512 columns of the page in sequential order and wraps around without ending, until another command stops it. A new command restarts the burst at any time. A burst-stop input ends the sequence at once. A clock-enable input freezes the generator with one clock of delay on both entry and exit.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, beat_valid and last_beat are low, and they stay low until a command is accepted.
- R2: A command (start high at a clock edge where the generator is not frozen) makes beat_valid high in the next cycle with col equal to start_col. Each later unfrozen clock edge then advances the burst by one beat.
- R3: len_sel values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any len_sel with bit 2 set selects full-page mode.
- R4: In sequential order (order = 0), beat n has col bits above the burst width equal to those of start_col. Its low bits are (start_col + n) modulo the burst length.
- R5: In interleaved order (order = 1), the low bits of beat n are start_col XOR n. For length 8 and a start of 2, the columns are 2, 3, 0, 1, 6, 7, 4, 5.
- R6: Full-page mode always uses sequential order, whatever the order input. It steps through all 512 columns, wrapping from 511 to 0, and it never ends by itself.
- R7: last_beat is high exactly on the final beat of a 1, 2, 4 or 8 beat burst and never in full-page mode. After the final beat, beat_valid goes low at the next unfrozen edge unless a new command is accepted there.
- R8: A command accepted during a burst drops the remaining beats and starts a fresh burst of the full new length at the new column. A command may be accepted on every clock.
- R9: stop accepted at an unfrozen edge without start makes beat_valid low from the next cycle. When start and stop come together, start wins.
- R10: cke sampled low at one edge freezes the next edge: col, beat_valid and last_beat hold, and start and stop are ignored there. Advancing resumes at the edge after the one where cke is sampled high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low suspends the burst one edge later |
| start | input | 1 | Read or write command accepted this cycle |
| start_col | input | 9 | Starting column of the new burst |
| len_sel | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, bit 2 set: full page) |
| order | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Burst-stop command |
| col | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is present this cycle |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The hardest situations to reach are those where several controls meet at one edge. These include a command arriving exactly on the last beat, a stop or a command landing on an edge that a cke pulse from the previous cycle has frozen, and a full-page burst running past its 511-to-0 wrap. Directed sequences cover the documented interleave order, the page wrap, back-to-back commands and single-cycle suspend pulses. A long seeded random run then mixes commands, stops and short cke drops at rates high enough that these coincidences happen many times. Every beat is compared against a cycle-level model in the bench.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } ord_e;

    typedef struct packed {
        logic       en;
        logic       active;
        logic       full;
        ord_e       ord;
        logic [8:0] mask;
        logic [8:0] base;
        logic [8:0] cnt;
    } colgen_st_t;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  logic [2:0]       len_sel,
    output logic [COL_W-1:0] mask,
    output logic             full
);
    logic [COL_W-1:0] short_mask;

    assign full = len_sel[2];

    generate
        for (genvar i = 0; i < COL_W; i++) begin : g_bit
            if (i < MAX_LOG) begin : g_low
                assign short_mask[i] = (32'(len_sel[1:0]) > i);
            end else begin : g_high
                assign short_mask[i] = 1'b0;
            end
        end
    endgenerate

    assign mask = full ? {COL_W{1'b1}} : short_mask;
endmodule

// File: rtl/colgen_col_calc.sv
module colgen_col_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    assign low_seq = (base + cnt) & mask;
    assign low_ilv = (base ^ cnt) & mask;
    assign col     = (base & ~mask) | (ilv ? low_ilv : low_seq);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_sel,
    input  logic             order,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             last_beat
);
    localparam int MAX_LOG = 3;

    colgen_st_t       st_d, st_q;
    logic [COL_W-1:0] new_mask;
    logic             new_full;
    logic             at_end;
    logic             en_q;

    colgen_len_decode #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_dec (
        .len_sel (len_sel),
        .mask    (new_mask),
        .full    (new_full)
    );

    colgen_col_calc #(.COL_W(COL_W)) u_calc (
        .base (st_q.base[COL_W-1:0]),
        .cnt  (st_q.cnt[COL_W-1:0]),
        .mask (st_q.mask[COL_W-1:0]),
        .ilv  (st_q.ord == ORD_ILV),
        .col  (col)
    );

    assign en_q   = st_q.en;
    assign at_end = !st_q.full && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d    = st_q;
        st_d.en = cke;
        if (st_q.en) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.full   = new_full;
                st_d.ord    = (order && !new_full) ? ORD_ILV : ORD_SEQ;
                st_d.mask   = new_mask;
                st_d.base   = start_col;
                st_d.cnt    = '0;
            end else if (stop) begin
                st_d.active = 1'b0;
            end else if (st_q.active) begin
                if (at_end) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.cnt = (st_q.cnt + 1'b1) & st_q.mask;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.en     <= 1'b1;
            st_q.ord    <= ORD_SEQ;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid = st_q.active;
    assign last_beat  = st_q.active && at_end;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic             en_q,
    input logic [COL_W-1:0] col,
    input logic             beat_valid,
    input logic             last_beat
);
    // R7
    last_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    // R2
    start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && start) |=> (beat_valid && col == $past(start_col)));

    // R9
    stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && stop && !start) |=> !beat_valid);

    // R10
    freeze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ($stable(col) && $stable(beat_valid) && $stable(last_beat)));

    // R7
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && last_beat && !start) |=> !beat_valid);

    // R8
    midburst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && beat_valid && !last_beat && !stop) |=> beat_valid);
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .start_col  (start_col),
    .en_q       (en_q),
    .col        (col),
    .beat_valid (beat_valid),
    .last_beat  (last_beat)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] start_col = '0;
    logic [2:0]    len_sel = '0;
    logic          order = 1'b0;
    logic          stop = 1'b0;
    logic [CW-1:0] col;
    logic          beat_valid;
    logic          last_beat;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // bench model state
    bit          m_en = 1;
    bit          m_act = 0;
    bit          m_full = 0;
    bit          m_ilv = 0;
    bit [CW-1:0] m_mask = '0;
    bit [CW-1:0] m_base = '0;
    bit [CW-1:0] m_cnt = '0;

    always #5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .len_sel(len_sel), .order(order), .stop(stop),
        .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
    );

    function automatic bit [CW-1:0] exp_col(bit [CW-1:0] b, bit [CW-1:0] n,
                                            bit [CW-1:0] m, bit ilv);
        if (ilv) return b ^ (n & m);
        return (b & ~m) | ((b + n) & m);
    endfunction

    function automatic bit [CW-1:0] len_mask(bit [2:0] ls);
        if (ls[2]) return '1;
        return CW'((1 << ls[1:0]) - 1);
    endfunction

    task automatic chk(string t, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic compare();
        bit e_last;
        e_last = m_act && !m_full && (m_cnt == m_mask);
        chk(tag, int'(beat_valid), int'(m_act), "beat_valid");
        chk(m_full ? "R6" : tag, int'(last_beat), int'(e_last), "last_beat");
        if (m_act)
            chk(tag, int'(col), int'(exp_col(m_base, m_cnt, m_mask, m_ilv)), "col");
    endtask

    task automatic model_step();
        bit nxt_en;
        nxt_en = cke;
        if (m_en) begin
            if (start) begin
                m_act  = 1;
                m_full = len_sel[2];
                m_ilv  = order && !len_sel[2];
                m_mask = len_mask(len_sel);
                m_base = start_col;
                m_cnt  = '0;
            end else if (stop) begin
                m_act = 0;
            end else if (m_act) begin
                if (!m_full && m_cnt == m_mask) m_act = 0;
                else m_cnt = (m_cnt + 1'b1) & m_mask;
            end
        end
        m_en = nxt_en;
    endtask

    // one cycle: check outputs, drive inputs, advance the model
    task automatic cyc(bit s, bit [CW-1:0] sc, bit [2:0] ls, bit o, bit sp, bit ck);
        @(negedge clk);
        compare();
        start = s; start_col = sc; len_sel = ls; order = o; stop = sp; cke = ck;
        model_step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 3'd0, 0, 0, 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [CW-1:0] ilv_ref [8];
        void'($urandom(32'd2718));
        ilv_ref = '{9'd2, 9'd3, 9'd0, 9'd1, 9'd6, 9'd7, 9'd4, 9'd5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        tag = "R1";
        idle(3);

        // R4 / R3: sequential length 4 from column 6 -> 6,7,4,5
        tag = "R4";
        cyc(1, 9'd6, 3'd2, 0, 0, 1);
        idle(6);

        // R5: interleaved length 8 from 2, explicit order
        tag = "R5";
        cyc(1, 9'd2, 3'd3, 1, 0, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R5", int'(col), int'(ilv_ref[i]), "interleave col");
            compare();
            start = 0; stop = 0; cke = 1;
            model_step();
        end
        idle(2);

        // R3 / R7: single-beat and two-beat bursts, upper bits held
        tag = "R3";
        cyc(1, 9'd301, 3'd0, 0, 0, 1);
        cyc(1, 9'd301, 3'd1, 1, 0, 1);
        idle(3);

        // R6: full page from 510 with order=1 ignored, past wrap
        tag = "R6";
        cyc(1, 9'd510, 3'd7, 1, 0, 1);
        idle(520);
        // R9: stop ends it
        tag = "R9";
        cyc(0, '0, 3'd0, 0, 1, 1);
        idle(2);
        // R9: start and stop together, start wins
        cyc(1, 9'd40, 3'd3, 0, 1, 1);
        idle(9);

        // R8: interrupt mid-burst, then a command on every clock
        tag = "R8";
        cyc(1, 9'd100, 3'd3, 0, 0, 1);
        idle(3);
        cyc(1, 9'd205, 3'd2, 1, 0, 1);
        for (int i = 0; i < 6; i++) cyc(1, CW'(i * 37), 3'(i % 4), i[0], 0, 1);
        idle(9);

        // R7: new command exactly on the last beat
        tag = "R7";
        cyc(1, 9'd12, 3'd1, 0, 0, 1);
        idle(1);
        cyc(1, 9'd77, 3'd2, 0, 0, 1);
        idle(6);

        // R10: suspend pulses, with commands on frozen edges
        tag = "R10";
        cyc(1, 9'd8, 3'd3, 0, 0, 1);
        cyc(0, '0, 3'd0, 0, 0, 0);
        cyc(1, 9'd400, 3'd0, 0, 0, 1);
        cyc(0, '0, 3'd0, 0, 1, 0);
        cyc(0, '0, 3'd0, 0, 1, 0);
        cyc(0, '0, 3'd0, 0, 0, 1);
        idle(10);

        // R2: seeded random mix
        tag = "R2";
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 6) == 0, CW'($urandom), 3'($urandom), 1'($urandom),
                ($urandom % 20) == 0, ($urandom % 8) != 0);
        end
        idle(12);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule